// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Arbiter

This block keeps the pending state of a small group of interrupt lines and offers the most urgent one to a processor core. Each line has its own priority and its own trigger mode. A line in edge mode remembers one event for each rising edge of its input, until a claim or a next-interrupt read takes that event. A line in level mode is pending for as long as its input is high. The arbiter compares the best pending priority with the level of the handler that is currently running. It raises a request only when the candidate is strictly more urgent and interrupts are globally enabled.

The core talks to the block through three single-cycle strobes. A claim means vectored entry: the core takes the offered line, the running level becomes that line's priority, the old level is saved in a one-deep register, and global enable drops. A next-interrupt read returns the best line above the running level and takes it if one exists. The read also sets global enable. A return restores the saved level and sets global enable. A lower-priority edge event that arrives during a handler therefore remains latched and is offered once the running level drops.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every line is in level mode with priority 0, no edge event is latched, the running level is 0, global enable is 1, and no request is raised even when an input is high.
- R2: In edge mode a rising input sets the line's pending bit on the following clock edge. The bit stays set after the input falls. An input that is held high gives only one event.
- R3: In level mode the pending bit equals the input in the same cycle, and a claim or next-interrupt read does not clear it.
- R4: The offered line (irq_id, irq_prio) is the pending line with the highest priority. Among equal priorities the lowest index wins. irq_id is 0 when nothing is pending.
- R5: irq_req is high exactly when some line is pending, the offered priority is strictly greater than act_lvl, and gie is 1.
- R6: A claim while irq_req is high sets act_lvl to the offered priority, saves the previous act_lvl, clears gie, and clears the offered line's pending bit if that line is in edge mode. A claim while irq_req is low has no effect.
- R7: During a next-interrupt read, nxt_hit is high when the offered priority exceeds act_lvl, whatever the value of gie, and nxt_id is then the offered line. On a hit the edge-mode pending bit of that line clears and act_lvl becomes its priority. Every read sets gie.
- R8: A next-interrupt read that finds no qualifying line reports nxt_hit 0 and nxt_id 0, and leaves act_lvl and every pending bit unchanged.
- R9: A return loads act_lvl from the saved level and sets gie. It takes precedence over a claim in the same cycle, and a claim takes precedence over a read.
- R10: A configuration write sets the addressed line's priority and mode and discards that line's latched edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| cfg_we | input | 1 | Line configuration write strobe |
| cfg_idx | input | IDX_W | Line addressed by the write |
| cfg_prio | input | PRIO_W | Priority to store |
| cfg_edge | input | 1 | 1 = edge mode, 0 = level mode |
| claim | input | 1 | Vectored claim strobe |
| nxt_rd | input | 1 | Next-interrupt read strobe |
| ret | input | 1 | Handler return strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | IDX_W | Offered line index |
| irq_prio | output | PRIO_W | Offered line priority |
| act_lvl | output | PRIO_W | Running handler level |
| gie | output | 1 | Global interrupt enable |
| nxt_hit | output | 1 | Read found a qualifying line |
| nxt_id | output | IDX_W | Line returned by the read |
| pend_o | output | NUM_LINES | Pending bit per line |

## Verification
The hardest case to reach is a lower-priority edge event that arrives while a more urgent handler runs. That line must stay latched through a read that misses, and it must be offered only after the return lowers the running level. The stimulus table builds this in several steps. It claims a line at priority 5 while an equal-priority line is also pending. A read then finds no line above the running level. After the return, the second line is offered and taken by a read, and the priority-1 line that has waited since earlier steps becomes visible again. Input lines are held high across these steps, so any spurious re-latch of an edge would show up.

// File: rtl/irq_arb_pkg.sv
// Package: shared types of the interrupt pending arbiter.
// Assumes: only one level-control operation takes effect per cycle.
package irq_arb_pkg;
    typedef enum logic [1:0] {
        LV_HOLD  = 2'd0,
        LV_RET   = 2'd1,
        LV_CLAIM = 2'd2,
        LV_NEXT  = 2'd3
    } lvl_op_e;
endpackage

// File: rtl/irq_line_cell.sv
// Module: one interrupt line holding its priority, mode and pending bit.
// Assumes: irq_in is already synchronous to clk; clr is one cycle wide.
module irq_line_cell #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              cfg_we,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              cfg_edge,
    input  logic              clr,
    output logic              pend,
    output logic [PRIO_W-1:0] prio,
    output logic              is_edge,
    output logic              edge_hit
);
    logic irq_q;
    logic latched;

    // Rising edge seen against the registered copy, only in edge mode
    assign edge_hit = is_edge & irq_in & ~irq_q;

    // Register the input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_in;
    end

    // Configuration storage for this line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio    <= '0;
            is_edge <= 1'b0;
        end else if (cfg_we) begin
            prio    <= cfg_prio;
            is_edge <= cfg_edge;
        end
    end

    // Latched edge event: a new edge wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we) latched <= 1'b0;
        else                  latched <= (latched & ~clr) | edge_hit;
    end

    // Pending view: latched event in edge mode, raw input in level mode
    assign pend = is_edge ? latched : irq_in;
endmodule

// File: rtl/irq_pick.sv
// Module: picks the highest-priority pending line, lowest index on ties.
// Assumes: purely combinational; index 0 and priority 0 when none pending.
module irq_pick #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]             pend,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             any,
    output logic [IDX_W-1:0]                 win_id,
    output logic [PRIO_W-1:0]                win_prio
);
    // Ascending scan; strict compare keeps the lowest index on ties
    always_comb begin
        any      = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (pend[i] && (!any || prio[i] > win_prio)) begin
                any      = 1'b1;
                win_id   = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_ctl.sv
// Module: running level, one-deep saved level and global enable.
// Assumes: op is already resolved for precedence by the parent.
module irq_level_ctl #(
    parameter int PRIO_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  irq_arb_pkg::lvl_op_e     op,
    input  logic                     nxt_take,
    input  logic [PRIO_W-1:0]        win_prio,
    output logic [PRIO_W-1:0]        act_lvl,
    output logic [PRIO_W-1:0]        saved_lvl,
    output logic                     gie
);
    import irq_arb_pkg::*;

    // Apply return, claim or next-interrupt read to the level state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lvl   <= '0;
            saved_lvl <= '0;
            gie       <= 1'b1;
        end else begin
            case (op)
                LV_RET: begin
                    act_lvl <= saved_lvl;
                    gie     <= 1'b1;
                end
                LV_CLAIM: begin
                    saved_lvl <= act_lvl;
                    act_lvl   <= win_prio;
                    gie       <= 1'b0;
                end
                LV_NEXT: begin
                    gie <= 1'b1;
                    if (nxt_take) act_lvl <= win_prio;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: interrupt pending arbiter top.
// Assumes: strobes are one cycle wide; return > claim > read in one cycle.
module irq_arbiter #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [PRIO_W-1:0]    cfg_prio,
    input  logic                 cfg_edge,
    input  logic                 claim,
    input  logic                 nxt_rd,
    input  logic                 ret,
    output logic                 irq_req,
    output logic [IDX_W-1:0]     irq_id,
    output logic [PRIO_W-1:0]    irq_prio,
    output logic [PRIO_W-1:0]    act_lvl,
    output logic                 gie,
    output logic                 nxt_hit,
    output logic [IDX_W-1:0]     nxt_id,
    output logic [NUM_LINES-1:0] pend_o
);
    import irq_arb_pkg::*;

    logic [NUM_LINES-1:0]             is_edge;
    logic [NUM_LINES-1:0]             edge_hit;
    logic [NUM_LINES-1:0]             clr_vec;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_vec;
    logic                             any;
    logic                             qualify;
    logic                             claim_ok;
    logic                             nxt_take;
    logic [PRIO_W-1:0]                saved_lvl;
    lvl_op_e                          op;

    // One cell per line
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cell #(.PRIO_W(PRIO_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[g]),
            .cfg_we   (cfg_we && (cfg_idx == IDX_W'(g))),
            .cfg_prio (cfg_prio),
            .cfg_edge (cfg_edge),
            .clr      (clr_vec[g]),
            .pend     (pend_o[g]),
            .prio     (prio_vec[g]),
            .is_edge  (is_edge[g]),
            .edge_hit (edge_hit[g])
        );
    end

    irq_pick #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick (
        .pend     (pend_o),
        .prio     (prio_vec),
        .any      (any),
        .win_id   (irq_id),
        .win_prio (irq_prio)
    );

    // Candidate must be strictly above the running level
    assign qualify  = any && (irq_prio > act_lvl);
    assign irq_req  = qualify && gie;
    assign claim_ok = claim && irq_req && !ret;
    assign nxt_take = nxt_rd && qualify && !ret && !claim_ok;
    assign nxt_hit  = nxt_rd && qualify;
    assign nxt_id   = nxt_hit ? irq_id : '0;

    // Resolve the single level operation of this cycle
    always_comb begin
        if (ret)           op = LV_RET;
        else if (claim_ok) op = LV_CLAIM;
        else if (nxt_rd)   op = LV_NEXT;
        else               op = LV_HOLD;
    end

    // Clear strobe to the taken line only
    always_comb begin
        clr_vec = '0;
        if (claim_ok || nxt_take) clr_vec[irq_id] = 1'b1;
    end

    irq_level_ctl #(.PRIO_W(PRIO_W)) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .nxt_take  (nxt_take),
        .win_prio  (irq_prio),
        .act_lvl   (act_lvl),
        .saved_lvl (saved_lvl),
        .gie       (gie)
    );
endmodule

// File: rtl/irq_arbiter_chk.sv
// Module: property checker bound into irq_arbiter.
// Assumes: observes ports plus a few internal nets; drives nothing.
module irq_arbiter_chk #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 nxt_rd,
    input logic                 ret,
    input logic                 irq_req,
    input logic [IDX_W-1:0]     irq_id,
    input logic [PRIO_W-1:0]    irq_prio,
    input logic [PRIO_W-1:0]    act_lvl,
    input logic                 gie,
    input logic                 nxt_hit,
    input logic [NUM_LINES-1:0] pend_o,
    input logic [NUM_LINES-1:0] is_edge,
    input logic [NUM_LINES-1:0] edge_hit,
    input logic [PRIO_W-1:0]    saved_lvl,
    input logic                 claim_ok
);
    // R5
    req_above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > act_lvl) && gie);

    // R6
    claim_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_ok |=> (act_lvl == $past(irq_prio)) && !gie);

    // R6
    claim_clears_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_ok && is_edge[irq_id] && !edge_hit[irq_id] |=> !pend_o[$past(irq_id)]);

    // R8
    miss_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_rd && !nxt_hit && !ret && !claim_ok |=> $stable(act_lvl) && gie);

    // R9
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret |=> (act_lvl == $past(saved_lvl)) && gie);

    // R2
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_edge
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[g] && is_edge[g] |=> pend_o[g]);
    end
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_rd    (nxt_rd),
    .ret       (ret),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .irq_prio  (irq_prio),
    .act_lvl   (act_lvl),
    .gie       (gie),
    .nxt_hit   (nxt_hit),
    .pend_o    (pend_o),
    .is_edge   (is_edge),
    .edge_hit  (edge_hit),
    .saved_lvl (saved_lvl),
    .claim_ok  (claim_ok)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
// Bench: table walk of arbitration steps, then directed corner cases.
module sim_irq_arbiter;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int IW = 3;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic          cfg_edge = 1'b0;
    logic          claim = 1'b0, nxt_rd = 1'b0, ret = 1'b0;
    logic          irq_req, gie, nxt_hit;
    logic [IW-1:0] irq_id, nxt_id;
    logic [PW-1:0] irq_prio, act_lvl;
    logic [N-1:0]  pend_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_arbiter #(.NUM_LINES(N), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_edge(cfg_edge),
        .claim(claim), .nxt_rd(nxt_rd), .ret(ret),
        .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
        .act_lvl(act_lvl), .gie(gie), .nxt_hit(nxt_hit), .nxt_id(nxt_id),
        .pend_o(pend_o)
    );

    // Vector: irq[8] | {claim,nxt,ret}[3] | exp req | exp id[3] | exp act[3] | exp gie
    localparam logic [18:0] VEC [NV] = '{
        {8'h00, 3'b000, 1'b0, 3'd0, 3'd0, 1'b1},
        {8'h02, 3'b000, 1'b1, 3'd1, 3'd0, 1'b1},
        {8'h00, 3'b000, 1'b1, 3'd1, 3'd0, 1'b1},
        {8'h00, 3'b100, 1'b0, 3'd0, 3'd2, 1'b0},
        {8'h40, 3'b000, 1'b0, 3'd6, 3'd2, 1'b0},
        {8'h40, 3'b001, 1'b1, 3'd6, 3'd0, 1'b1},
        {8'h44, 3'b000, 1'b1, 3'd2, 3'd0, 1'b1},
        {8'h54, 3'b000, 1'b1, 3'd2, 3'd0, 1'b1},
        {8'h54, 3'b100, 1'b0, 3'd4, 3'd5, 1'b0},
        {8'h54, 3'b010, 1'b0, 3'd4, 3'd5, 1'b1},
        {8'h54, 3'b001, 1'b1, 3'd4, 3'd0, 1'b1},
        {8'h54, 3'b010, 1'b0, 3'd6, 3'd5, 1'b1},
        {8'h5C, 3'b000, 1'b0, 3'd3, 3'd5, 1'b1},
        {8'h5C, 3'b001, 1'b1, 3'd3, 3'd0, 1'b1},
        {8'h5C, 3'b100, 1'b0, 3'd3, 3'd3, 1'b0},
        {8'h54, 3'b000, 1'b0, 3'd6, 3'd3, 1'b0},
        {8'h54, 3'b001, 1'b1, 3'd6, 3'd0, 1'b1},
        {8'h54, 3'b101, 1'b1, 3'd6, 3'd0, 1'b1},
        {8'h54, 3'b100, 1'b0, 3'd0, 3'd1, 1'b0},
        {8'h00, 3'b010, 1'b0, 3'd0, 3'd1, 1'b1}
    };

    // Compare one value and log a miscompare
    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and return just after the clock edge
    task automatic step(input logic [N-1:0] irq, input logic c, input logic n, input logic r);
        @(negedge clk);
        irq_in = irq; claim = c; nxt_rd = n; ret = r;
        @(posedge clk);
        #1;
        claim = 1'b0; nxt_rd = 1'b0; ret = 1'b0;
        #1;
    endtask

    // Write one line's configuration
    task automatic cfg(input int idx, input int p, input logic e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_prio = PW'(p); cfg_edge = e;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pend", int'(pend_o), 0);
        chk("R1 act_lvl", int'(act_lvl), 0);
        chk("R1 gie", int'(gie), 1);
        chk("R1 irq_req", int'(irq_req), 0);
        // R1 unconfigured line: level mode, priority 0, never requests
        @(negedge clk); irq_in = 8'h80; #1;
        chk("R1 level pend", int'(pend_o), 8'h80);
        chk("R1 prio0 no req", int'(irq_req), 0);
        irq_in = '0;

        cfg(1, 2, 1'b1);
        cfg(2, 5, 1'b1);
        cfg(3, 3, 1'b0);
        cfg(4, 5, 1'b1);
        cfg(6, 1, 1'b1);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][18:11], VEC[v][10], VEC[v][9], VEC[v][8]);
            chk($sformatf("R5 vec %0d irq_req", v), int'(irq_req), int'(VEC[v][7]));
            chk($sformatf("R4 vec %0d irq_id", v), int'(irq_id), int'(VEC[v][6:4]));
            chk($sformatf("R6 R9 vec %0d act_lvl", v), int'(act_lvl), int'(VEC[v][3:1]));
            chk($sformatf("R7 vec %0d gie", v), int'(gie), int'(VEC[v][0]));
        end

        // R2 latch survives input drop (line 6 latched at vector 4, cleared at 18)
        chk("R2 no stale pend", int'(pend_o), 0);

        // R7 read hit reported combinationally, then taken
        step(8'h04, 1'b0, 1'b0, 1'b0);
        chk("R2 edge latched", int'(pend_o[2]), 1);
        @(negedge clk); nxt_rd = 1'b1; #1;
        chk("R7 nxt_hit", int'(nxt_hit), 1);
        chk("R7 nxt_id", int'(nxt_id), 2);
        @(posedge clk); #1; nxt_rd = 1'b0; #1;
        chk("R7 pend cleared", int'(pend_o[2]), 0);
        chk("R7 act_lvl", int'(act_lvl), 5);

        // R8 read miss reports zero
        @(negedge clk); nxt_rd = 1'b1; #1;
        chk("R8 nxt_hit", int'(nxt_hit), 0);
        chk("R8 nxt_id", int'(nxt_id), 0);
        @(posedge clk); #1; nxt_rd = 1'b0; #1;

        // R6 claim without request is ignored
        step(8'h04, 1'b1, 1'b0, 1'b0);
        chk("R6 ignored act", int'(act_lvl), 5);
        chk("R6 ignored gie", int'(gie), 1);

        // R10 configuration write drops a latched edge
        step(8'h04, 1'b0, 1'b0, 1'b1);
        cfg(5, 7, 1'b1);
        step(8'h24, 1'b0, 1'b0, 1'b0);
        chk("R10 pend before", int'(pend_o[5]), 1);
        chk("R10 winner", int'(irq_id), 5);
        cfg(5, 7, 1'b1);
        chk("R10 pend dropped", int'(pend_o[5]), 0);
        chk("R10 no req", int'(irq_req), 0);

        // R3 level line survives its own claim
        step(8'h0C, 1'b0, 1'b0, 1'b0);
        step(8'h0C, 1'b1, 1'b0, 1'b0);
        chk("R3 level kept", int'(pend_o[3]), 1);
        chk("R3 act_lvl", int'(act_lvl), 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule